// File: doc/BRIEF.md
# Unipolar T1/E1 Line Code Encoder

This block turns a single-rail NRZ transmit stream into a pair of positive and negative pulse flags for a line interface. Three line codes are available: alternate mark inversion, eight-zero substitution for T1, and four-zero substitution for E1. A transmit-all-ones request overrides the data with an unbroken train of marks. When unipolar coding is switched off, the two data inputs already carry bipolar NRZ from an external framer and pass through to the outputs unchanged.

One instance encodes one channel. In a multi-channel line card every instance is wired to the same code-select inputs, so one selection governs all channels together. Data is captured on the falling edge of the transmit clock. Everything after the capture runs on the rising edge. Every bit passes through a fixed eight-symbol look-ahead buffer, so that a zero run can be replaced before any of its bits has left.

Top module: `lc_line_encoder`

## Requirements
- R1: A synchronous reset held over a rising edge drives `pos_out` and `neg_out` low. After reset, the first normal mark comes out on `pos_out`.
- R2: A bit captured on a falling edge reaches the outputs just after the ninth rising edge that follows. This latency is the same in every code mode and in pass-through.
- R3: With `uni_en`=1 and `zsub_en`=0, a data 1 gives one pulse whose polarity is opposite to the previous pulse. A data 0 gives no pulse. In unipolar mode `pos_out` and `neg_out` are never high together.
- R4: With `uni_en`=1, `zsub_en`=1 and `e1_sel`=0, eight zeros in a row leave in time order as 0,0,0,V,B,0,V,B. Here V repeats the polarity of the pulse before it, and B alternates normally.
- R5: With `uni_en`=1, `zsub_en`=1 and `e1_sel`=1, four zeros in a row leave as 0,0,0,V when an odd number of pulses have gone out since the last V. Otherwise they leave as B,0,0,V. Reset counts as an even number.
- R6: While `all_ones`=1, every captured bit is a mark that alternates polarity, in any mode. `tx_data` and `tx_neg` have no effect.
- R7: With `uni_en`=0, `pos_out` and `neg_out` repeat `tx_data` and `tx_neg` unmodified, and both may be high together. With `uni_en`=1, `tx_neg` has no effect.
- R8: A zero that has been replaced is not counted again. Under the eight-zero code, 16 zeros give two substitutions, 9 zeros give one substitution plus one plain zero, and 7 zeros give none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock. Data is captured on the falling edge, and the rest of the logic runs on the rising edge. |
| rst | input | 1 | Synchronous active-high reset. |
| uni_en | input | 1 | 1 selects unipolar coding, 0 selects bipolar pass-through. |
| zsub_en | input | 1 | 1 selects zero substitution, 0 selects plain alternate mark inversion. Shared by all channels. |
| e1_sel | input | 1 | Substitution flavour: 1 selects the four-zero E1 code, 0 selects the eight-zero T1 code. Shared by all channels. |
| all_ones | input | 1 | Transmit-all-ones request. |
| tx_data | input | 1 | Unipolar data, or the positive rail in pass-through. |
| tx_neg | input | 1 | Negative rail in pass-through. Unused in unipolar mode. |
| pos_out | output | 1 | Registered positive pulse flag. |
| neg_out | output | 1 | Registered negative pulse flag. |

## Verification
Inputs are set 1 ns after a rising edge. The falling edge 1 ns later captures them. The pulse pair for that bit is expected on the ninth rising edge after that falling edge.

The bench's behavioural model applies the zero substitutions to its own symbol queue. It releases a symbol only once eight newer bits exist behind it, which settles every substitution, and then assigns the symbol its polarity. The expected pair goes into a two-entry queue, and that entry is compared 1 ns after the rising edge at which it falls due. This makes every rising edge after reset a compared vector, including the idle symbols that drain out of the buffer right after reset.

// File: rtl/lc_enc_pkg.sv
package lc_enc_pkg;

  // Run lengths of the two substitution codes.
  localparam int LONG_RUN  = 8;
  localparam int SHORT_RUN = 4;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_MARK = 2'd1,
    SYM_VIOL = 2'd2,
    SYM_BAL  = 2'd3
  } sym_e;

  // raw = 1: code holds {pos, neg} to be sent unmodified.
  // raw = 0: code holds a sym_e whose polarity is chosen at the output.
  typedef struct packed {
    logic       raw;
    logic [1:0] code;
  } tok_t;

  localparam tok_t TOK_IDLE = '{raw: 1'b1, code: 2'b00};

  function automatic tok_t mk_tok(sym_e k);
    mk_tok = '{raw: 1'b0, code: k};
  endfunction

  function automatic logic is_sym(tok_t t, sym_e k);
    return !t.raw && (t.code == k);
  endfunction

endpackage

// File: rtl/lc_enc_capture.sv
module lc_enc_capture
  import lc_enc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic uni_en,
  input  logic zsub_en,
  input  logic e1_sel,
  input  logic all_ones,
  input  logic tx_data,
  input  logic tx_neg,
  output tok_t cap_tok,
  output logic cap_zsub,
  output logic cap_e1
);

  // The falling edge samples the data. Each bit keeps the mode that was
  // present when it was taken in.
  always_ff @(negedge clk) begin
    if (rst) begin
      cap_tok  <= TOK_IDLE;
      cap_zsub <= 1'b0;
      cap_e1   <= 1'b0;
    end else begin
      if (all_ones)
        cap_tok <= mk_tok(SYM_MARK);
      else if (!uni_en)
        cap_tok <= '{raw: 1'b1, code: {tx_data, tx_neg}};
      else
        cap_tok <= mk_tok(tx_data ? SYM_MARK : SYM_ZERO);
      cap_zsub <= uni_en & zsub_en;
      cap_e1   <= e1_sel;
    end
  end

endmodule

// File: rtl/lc_enc_subst.sv
module lc_enc_subst
  import lc_enc_pkg::*;
#(
  parameter int DEPTH     = LONG_RUN,
  parameter int RUN_LONG  = LONG_RUN,
  parameter int RUN_SHORT = SHORT_RUN
) (
  input  logic clk,
  input  logic rst,
  input  tok_t cap_tok,
  input  logic cap_zsub,
  input  logic cap_e1,
  output tok_t tail_tok
);

  localparam int TAP = RUN_SHORT;   // first stage behind the short window

  tok_t pipe_q  [DEPTH];
  tok_t shift_d [DEPTH];
  tok_t sub_d   [DEPTH];
  logic odd_q;
  logic par_now;
  logic long_zero;
  logic short_zero;

  always_comb begin
    shift_d[0] = cap_tok;
    for (int i = 1; i < DEPTH; i++) shift_d[i] = pipe_q[i-1];

    long_zero = 1'b1;
    for (int i = 0; i < RUN_LONG; i++)
      long_zero = long_zero & is_sym(shift_d[i], SYM_ZERO);
    short_zero = 1'b1;
    for (int i = 0; i < RUN_SHORT; i++)
      short_zero = short_zero & is_sym(shift_d[i], SYM_ZERO);

    sub_d = shift_d;

    // Eight-zero code: oldest first 0 0 0 V B 0 V B.
    if (cap_zsub && !cap_e1 && long_zero) begin
      sub_d[RUN_LONG-4] = mk_tok(SYM_VIOL);
      sub_d[RUN_LONG-5] = mk_tok(SYM_BAL);
      sub_d[RUN_LONG-7] = mk_tok(SYM_VIOL);
      sub_d[RUN_LONG-8] = mk_tok(SYM_BAL);
    end

    // Parity of the pulses since the last violation, up to and including
    // the symbol just ahead of the short window.
    if (is_sym(sub_d[TAP], SYM_VIOL))
      par_now = 1'b0;
    else
      par_now = odd_q ^ (is_sym(sub_d[TAP], SYM_MARK) | is_sym(sub_d[TAP], SYM_BAL));

    // Four-zero code: 0 0 0 V after an odd count, B 0 0 V after an even one.
    if (cap_zsub && cap_e1 && short_zero) begin
      sub_d[0] = mk_tok(SYM_VIOL);
      if (!par_now) sub_d[RUN_SHORT-1] = mk_tok(SYM_BAL);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= TOK_IDLE;
      odd_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= sub_d[i];
      odd_q <= par_now;
    end
  end

  assign tail_tok = pipe_q[DEPTH-1];

endmodule

// File: rtl/lc_enc_polarity.sv
module lc_enc_polarity
  import lc_enc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  tok_t tail_tok,
  output logic pos_q,
  output logic neg_q
);

  logic last_neg_q;   // 1: the last pulse was negative

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= 1'b0;
      neg_q      <= 1'b0;
      last_neg_q <= 1'b1;
    end else if (tail_tok.raw) begin
      pos_q <= tail_tok.code[1];
      neg_q <= tail_tok.code[0];
    end else begin
      case (sym_e'(tail_tok.code))
        SYM_MARK, SYM_BAL: begin
          pos_q      <= last_neg_q;
          neg_q      <= !last_neg_q;
          last_neg_q <= !last_neg_q;
        end
        SYM_VIOL: begin
          pos_q <= !last_neg_q;
          neg_q <= last_neg_q;
        end
        default: begin
          pos_q <= 1'b0;
          neg_q <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/lc_line_encoder.sv
module lc_line_encoder
  import lc_enc_pkg::*;
#(
  parameter int PIPE_DEPTH = LONG_RUN
) (
  input  logic clk,
  input  logic rst,
  input  logic uni_en,
  input  logic zsub_en,
  input  logic e1_sel,
  input  logic all_ones,
  input  logic tx_data,
  input  logic tx_neg,
  output logic pos_out,
  output logic neg_out
);

  tok_t cap_tok;
  tok_t tail_tok;
  logic cap_zsub;
  logic cap_e1;

  lc_enc_capture u_capture (
    .clk      (clk),
    .rst      (rst),
    .uni_en   (uni_en),
    .zsub_en  (zsub_en),
    .e1_sel   (e1_sel),
    .all_ones (all_ones),
    .tx_data  (tx_data),
    .tx_neg   (tx_neg),
    .cap_tok  (cap_tok),
    .cap_zsub (cap_zsub),
    .cap_e1   (cap_e1)
  );

  lc_enc_subst #(
    .DEPTH     (PIPE_DEPTH),
    .RUN_LONG  (LONG_RUN),
    .RUN_SHORT (SHORT_RUN)
  ) u_subst (
    .clk      (clk),
    .rst      (rst),
    .cap_tok  (cap_tok),
    .cap_zsub (cap_zsub),
    .cap_e1   (cap_e1),
    .tail_tok (tail_tok)
  );

  lc_enc_polarity u_polarity (
    .clk      (clk),
    .rst      (rst),
    .tail_tok (tail_tok),
    .pos_q    (pos_out),
    .neg_q    (neg_out)
  );

endmodule

// File: rtl/lc_line_encoder_chk.sv
module lc_line_encoder_chk
  import lc_enc_pkg::*;
(
  input logic clk,
  input logic rst,
  input tok_t tail_tok,
  input logic pos_out,
  input logic neg_out
);

  // Polarity of the last coded pulse, followed from the output ports.
  logic plain_q;
  logic seen_neg;

  always_ff @(posedge clk) begin
    if (rst) begin
      plain_q  <= 1'b0;
      seen_neg <= 1'b1;
    end else begin
      plain_q <= !tail_tok.raw;
      if (plain_q && (pos_out ^ neg_out)) seen_neg <= neg_out;
    end
  end

  AST_MARK_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (is_sym(tail_tok, SYM_MARK) || is_sym(tail_tok, SYM_BAL)) |=> (pos_out == seen_neg) && (neg_out == !seen_neg)); // R3

  AST_VIOL_REPEATS: assert property (@(posedge clk) disable iff (rst)
    is_sym(tail_tok, SYM_VIOL) |=> (pos_out == !seen_neg) && (neg_out == seen_neg)); // R4

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
    is_sym(tail_tok, SYM_ZERO) |=> !pos_out && !neg_out); // R3

  AST_CODED_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !tail_tok.raw |=> !(pos_out && neg_out)); // R3

  AST_RAW_THROUGH: assert property (@(posedge clk) disable iff (rst)
    tail_tok.raw |=> ({pos_out, neg_out} == $past(tail_tok.code))); // R7

endmodule

bind lc_line_encoder lc_line_encoder_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tail_tok (tail_tok),
  .pos_out  (pos_out),
  .neg_out  (neg_out)
);

// File: tb/lc_line_encoder_bench.sv
`timescale 1ns/1ps
module lc_line_encoder_bench;

  localparam int K_ZERO = 0;
  localparam int K_MARK = 1;
  localparam int K_VIOL = 2;
  localparam int K_BAL  = 3;
  localparam int K_RAW  = 8;   // K_RAW + 2*pos + neg

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uni_en = 1'b1, zsub_en = 1'b0, e1_sel = 1'b0;
  logic all_ones = 1'b0, tx_data = 1'b0, tx_neg = 1'b0;
  logic pos_out, neg_out;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  int pend[$];
  int exp_q[$];
  int zrun;
  bit par;
  bit last_neg;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  lc_line_encoder u_lc_line_encoder (
    .clk(clk), .rst(rst), .uni_en(uni_en), .zsub_en(zsub_en), .e1_sel(e1_sel),
    .all_ones(all_ones), .tx_data(tx_data), .tx_neg(tx_neg),
    .pos_out(pos_out), .neg_out(neg_out)
  );

  function automatic void note_par(int k);
    if (k == K_VIOL) par = 1'b0;
    else if (k == K_MARK || k == K_BAL) par = ~par;
  endfunction

  function automatic void model_clear();
    pend.delete();
    repeat (7) pend.push_back(K_RAW);
    zrun = 0;
    par = 1'b0;
    last_neg = 1'b1;
    exp_q.delete();
    exp_q.push_back(0);
  endfunction

  function automatic void model_push(bit d, bit n, bit ao);
    int k;
    int f;
    int o;
    int pat[8];
    pat = '{K_ZERO, K_ZERO, K_ZERO, K_VIOL, K_BAL, K_ZERO, K_VIOL, K_BAL};
    if (ao) k = K_MARK;
    else if (!uni_en) k = K_RAW + 2 * int'(d) + int'(n);
    else k = d ? K_MARK : K_ZERO;
    pend.push_back(k);
    note_par(k);
    zrun = (k == K_ZERO) ? zrun + 1 : 0;
    if (uni_en && zsub_en && !e1_sel && zrun == 8) begin
      for (int i = 0; i < 8; i++) begin
        pend[pend.size() - 8 + i] = pat[i];
        note_par(pat[i]);
      end
      zrun = 0;
    end else if (uni_en && zsub_en && e1_sel && zrun == 4) begin
      pend[pend.size() - 1] = K_VIOL;
      if (!par) pend[pend.size() - 4] = K_BAL;
      par = 1'b0;
      zrun = 0;
    end
    if (pend.size() == 8) begin
      f = pend.pop_front();
      if (f >= K_RAW) o = f - K_RAW;
      else if (f == K_MARK || f == K_BAL) begin
        o = last_neg ? 2 : 1;
        last_neg = ~last_neg;
      end else if (f == K_VIOL) o = last_neg ? 1 : 2;
      else o = 0;
      exp_q.push_back(o);
    end
  endfunction

  task automatic check_pair(int e, string tag);
    int a;
    a = 2 * int'(pos_out) + int'(neg_out);
    vectors++;
    if (a != e) begin
      fails++;
      $display("FAIL %s at %0t: pos/neg=%0d%0d expected %0d%0d", tag, $time,
               a / 2, a % 2, e / 2, e % 2);
    end
  endtask

  task automatic start(bit u, bit z, bit e, string tag);
    uni_en = u; zsub_en = z; e1_sel = e;
    all_ones = 1'b0; tx_data = 1'b0; tx_neg = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_pair(0, "R1");
    rst = 1'b0;
    model_clear();
  endtask

  task automatic step(bit d, bit n, bit ao, string tag);
    tx_data = d; tx_neg = n; all_ones = ao;
    model_push(d, n, ao);
    @(posedge clk);
    #1;
    check_pair(exp_q.pop_front(), tag);
  endtask

  task automatic seq(string s, string tag);
    for (int i = 0; i < s.len(); i++) step(s[i] == "1", 1'b0, 1'b0, tag);
  endtask

  task automatic flush(string tag);
    repeat (12) step(1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic rand_run(int cnt, string tag);
    for (int i = 0; i < cnt; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] & lf[5], lf[7], 1'b0, tag);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      report();
    end
  end

  initial begin
    // R1: first mark after reset is positive
    start(1, 0, 0, "R1");
    seq("1", "R1");
    flush("R1");
    // R2: single mark shows up on the ninth rising edge
    start(1, 0, 0, "R2");
    seq("10000000001", "R2");
    flush("R2");
    // R3: alternate mark inversion, long zero runs untouched
    start(1, 0, 0, "R3");
    seq("1101000000000110101", "R3");
    flush("R3");
    rand_run(200, "R3");
    // R4: eight-zero substitution
    start(1, 1, 0, "R4");
    seq("10000000011", "R4");
    flush("R4");
    rand_run(300, "R4");
    // R8: no double counting of replaced zeros
    start(1, 1, 0, "R8");
    seq("100000000000000001000000010000000001", "R8");
    flush("R8");
    // R5: four-zero substitution, even count right after reset
    start(1, 1, 1, "R5");
    seq("0000100001100000000000001000111", "R5");
    flush("R5");
    rand_run(300, "R5");
    // R6: all ones overrides data in unipolar and in pass-through
    start(1, 1, 1, "R6");
    repeat (24) step(1'b0, 1'b1, 1'b1, "R6");
    seq("000000", "R6");
    flush("R6");
    start(0, 0, 0, "R6");
    repeat (16) step(1'b1, 1'b1, 1'b1, "R6");
    flush("R6");
    // R7: bipolar pass-through, both rails may be high
    start(0, 0, 0, "R7");
    for (int i = 0; i < 150; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[2], lf[9], 1'b0, "R7");
    end
    flush("R7");
    done = 1'b1;
    report();
  end

endmodule